// File: doc/BRIEF.md
# Operand Locator and Address Former

This unit turns a decoded operand-location code into either a ready operand value or a byte address for a later memory access. Each request carries a three-bit location code, a signed 16-bit constant from the instruction word, and the contents of up to two general registers, called the first register and the second register. The unit adds together whichever of these three terms the code asks for. It registers the result and tells the next stage whether that result is a value or an address, and whether memory must be read.

The unit sits between instruction decode and the load/store stage. It never writes a register. Reading operands, accessing memory and any pointer update belong to the surrounding pipeline. A request strobe captures the inputs, and a valid strobe marks the registered answer on the following cycle. Between requests the answer stays where it was.

Top module: `eagu_top`

## Requirements
- R1: Location code 0 (register) returns the first register as the operand, with addr_flag 0 and mem_req 0.
- R2: Code 1 (absolute) returns the sign-extended constant as an address, with addr_flag 1 and mem_req 1.
- R3: Code 2 (immediate) returns the sign-extended constant as an operand, with addr_flag 0 and mem_req 0.
- R4: Code 3 (indirect) returns the first register as an address, with mem_req 1.
- R5: Code 4 (indexed) returns the sign-extended constant plus the first register, modulo 2^32, as an address.
- R6: Code 5 (two-register) returns the first register plus the second register, modulo 2^32, as an address.
- R7: Code 6 (two-register plus constant) returns the sign-extended constant plus both registers, modulo 2^32, as an address.
- R8: Code 7 is undefined. It raises bad_mode, gives a zero result, and clears mem_req and addr_flag.
- R9: valid_o is high exactly in the cycle after a cycle in which req_i was sampled high, and low otherwise.
- R10: While no request is sampled, the result and all flags keep their last values.
- R11: After reset, valid_o, the result and all flags read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 1 | Request strobe; samples the other inputs |
| mode_i | input | 3 | Operand-location code |
| disp_i | input | 16 | Signed constant from the instruction |
| ri_i | input | 32 | First register contents |
| rj_i | input | 32 | Second register contents |
| valid_o | output | 1 | Result valid, one cycle after req_i |
| result_o | output | 32 | Operand value or byte address |
| addr_flag_o | output | 1 | 1 when result_o is an address |
| mem_req_o | output | 1 | 1 when a memory access is needed |
| bad_mode_o | output | 1 | Undefined location code |

## Verification
The assertions assume that the request inputs are stable across the sampling edge. They also assume that req_i stays low while reset is applied and during the two cycles of synchronous release. The bench meets both assumptions by driving every input on the falling edge and by waiting out the release before it issues a request. The stimulus covers every code, including the undefined one. It mixes back-to-back requests with idle gaps and uses constants and register values chosen to cross the 2^32 wrap and the sign boundary of the constant.

// File: rtl/eagu_pkg.sv
package eagu_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    LOC_REG    = 3'd0,
    LOC_ABS    = 3'd1,
    LOC_IMM    = 3'd2,
    LOC_IND    = 3'd3,
    LOC_IDX    = 3'd4,
    LOC_BI     = 3'd5,
    LOC_BIX    = 3'd6,
    LOC_UNDEF  = 3'd7
  } loc_mode_e;

  typedef struct packed {
    logic take_disp;
    logic take_ri;
    logic take_rj;
    logic is_addr;
    logic needs_mem;
    logic bad;
  } loc_ctrl_t;
endpackage

// File: rtl/eagu_decode.sv
module eagu_decode
  import eagu_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output loc_ctrl_t         ctrl_o
);
  always_comb begin
    ctrl_o = '0;
    unique case (loc_mode_e'(mode_i))
      LOC_REG: ctrl_o.take_ri = 1'b1;
      LOC_ABS: begin
        ctrl_o.take_disp = 1'b1;
        ctrl_o.is_addr   = 1'b1;
        ctrl_o.needs_mem = 1'b1;
      end
      LOC_IMM: ctrl_o.take_disp = 1'b1;
      LOC_IND: begin
        ctrl_o.take_ri   = 1'b1;
        ctrl_o.is_addr   = 1'b1;
        ctrl_o.needs_mem = 1'b1;
      end
      LOC_IDX: begin
        ctrl_o.take_disp = 1'b1;
        ctrl_o.take_ri   = 1'b1;
        ctrl_o.is_addr   = 1'b1;
        ctrl_o.needs_mem = 1'b1;
      end
      LOC_BI: begin
        ctrl_o.take_ri   = 1'b1;
        ctrl_o.take_rj   = 1'b1;
        ctrl_o.is_addr   = 1'b1;
        ctrl_o.needs_mem = 1'b1;
      end
      LOC_BIX: begin
        ctrl_o.take_disp = 1'b1;
        ctrl_o.take_ri   = 1'b1;
        ctrl_o.take_rj   = 1'b1;
        ctrl_o.is_addr   = 1'b1;
        ctrl_o.needs_mem = 1'b1;
      end
      default: ctrl_o.bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/eagu_sum3.sv
module eagu_sum3 #(
  parameter int DATA_W = 32,
  parameter int DISP_W = 16
) (
  input  logic [DISP_W-1:0] disp_i,
  input  logic [DATA_W-1:0] ri_i,
  input  logic [DATA_W-1:0] rj_i,
  input  logic              take_disp_i,
  input  logic              take_ri_i,
  input  logic              take_rj_i,
  output logic [DATA_W-1:0] sum_o
);
  localparam int EXT_W = DATA_W - DISP_W;

  logic [DATA_W-1:0] disp_ext;
  logic [DATA_W-1:0] term_d, term_i, term_j;

  generate
    if (EXT_W > 0) begin : g_sext
      assign disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
    end else begin : g_trunc
      assign disp_ext = disp_i[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    term_d = take_disp_i ? disp_ext : '0;
    term_i = take_ri_i   ? ri_i     : '0;
    term_j = take_rj_i   ? rj_i     : '0;
    sum_o  = term_d + term_i + term_j;
  end
endmodule

// File: rtl/eagu_top.sv
module eagu_top
  import eagu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DISP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [2:0]        mode_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [DATA_W-1:0] ri_i,
  input  logic [DATA_W-1:0] rj_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              addr_flag_o,
  output logic              mem_req_o,
  output logic              bad_mode_o
);
  logic [1:0] rst_pipe;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  loc_ctrl_t         ctrl;
  logic [DATA_W-1:0] sum;

  eagu_decode u_dec (.mode_i(mode_i), .ctrl_o(ctrl));

  eagu_sum3 #(.DATA_W(DATA_W), .DISP_W(DISP_W)) u_sum (
    .disp_i(disp_i), .ri_i(ri_i), .rj_i(rj_i),
    .take_disp_i(ctrl.take_disp), .take_ri_i(ctrl.take_ri),
    .take_rj_i(ctrl.take_rj), .sum_o(sum)
  );

  logic              valid_d;
  logic [DATA_W-1:0] result_d;
  logic              addr_d, mem_d, bad_d;

  always_comb begin
    valid_d  = req_i;
    result_d = result_o;
    addr_d   = addr_flag_o;
    mem_d    = mem_req_o;
    bad_d    = bad_mode_o;
    if (req_i) begin
      result_d = ctrl.bad ? '0 : sum;
      addr_d   = ctrl.is_addr;
      mem_d    = ctrl.needs_mem;
      bad_d    = ctrl.bad;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      valid_o     <= 1'b0;
      result_o    <= '0;
      addr_flag_o <= 1'b0;
      mem_req_o   <= 1'b0;
      bad_mode_o  <= 1'b0;
    end else begin
      valid_o     <= valid_d;
      result_o    <= result_d;
      addr_flag_o <= addr_d;
      mem_req_o   <= mem_d;
      bad_mode_o  <= bad_d;
    end
  end

  p_valid_after_req_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    req_i |=> valid_o);
  p_valid_idle_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    !req_i |=> !valid_o);
  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    !valid_o |-> $stable(result_o) && $stable(mem_req_o) && $stable(bad_mode_o));
  p_undef_zero_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    valid_o && bad_mode_o |-> result_o == '0 && !mem_req_o && !addr_flag_o);
  p_reg_mode_r1: assert property (@(posedge clk) disable iff (!rst_q_n)
    valid_o && $past(mode_i) == 3'd0 |-> result_o == $past(ri_i) && !mem_req_o);
  p_two_reg_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    valid_o && $past(mode_i) == 3'd5 |-> result_o == $past(ri_i) + $past(rj_i) && mem_req_o);
  p_mem_implies_addr_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    mem_req_o |-> addr_flag_o && !bad_mode_o);
endmodule

// File: tb/eagu_top_bench.sv
module eagu_top_bench;
  typedef struct {
    logic [31:0] res;
    logic        addr, mem, bad;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 1'b0;
  logic [2:0]  mode_i = '0;
  logic [15:0] disp_i = '0;
  logic [31:0] ri_i = '0, rj_i = '0;
  logic        valid_o, addr_flag_o, mem_req_o, bad_mode_o;
  logic [31:0] result_o;

  int   n_run = 0, n_fail = 0;
  exp_t q[$];
  exp_t last;
  bit   mon_on = 0;

  always #2.5 clk = ~clk;

  eagu_top u_eagu_top (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [2:0] m, input logic [15:0] d,
                                 input logic [31:0] a, input logic [31:0] b);
    exp_t e;
    logic [31:0] x;
    x = {{16{d[15]}}, d};
    e.bad = 0; e.addr = 1; e.mem = 1;
    case (m)
      3'd0: begin e.res = a;         e.addr = 0; e.mem = 0; e.tag = "R1"; end
      3'd1: begin e.res = x;         e.tag = "R2"; end
      3'd2: begin e.res = x;         e.addr = 0; e.mem = 0; e.tag = "R3"; end
      3'd3: begin e.res = a;         e.tag = "R4"; end
      3'd4: begin e.res = x + a;     e.tag = "R5"; end
      3'd5: begin e.res = a + b;     e.tag = "R6"; end
      3'd6: begin e.res = x + a + b; e.tag = "R7"; end
      default: begin e.res = 0; e.addr = 0; e.mem = 0; e.bad = 1; e.tag = "R8"; end
    endcase
    return e;
  endfunction

  task automatic send(input logic [2:0] m, input logic [15:0] d,
                      input logic [31:0] a, input logic [31:0] b, input int gap);
    @(negedge clk);
    req_i = 1; mode_i = m; disp_i = d; ri_i = a; rj_i = b;
    q.push_back(model(m, d, a, b));
    @(negedge clk);
    req_i = 0; mode_i = $urandom; disp_i = $urandom; ri_i = $urandom; rj_i = $urandom;
    for (int g = 1; g < gap; g++) @(negedge clk);
  endtask

  task automatic send_b2b(input logic [2:0] m, input logic [15:0] d,
                          input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    req_i = 1; mode_i = m; disp_i = d; ri_i = a; rj_i = b;
    q.push_back(model(m, d, a, b));
  endtask

  // monitor: compares just after each falling edge
  always @(negedge clk) begin
    #1;
    if (mon_on) begin
      if (valid_o) begin
        if (q.size() == 0) chk(0, "R9 unexpected valid", 32'd1, 32'd0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(result_o == e.res, {e.tag, " result"}, result_o, e.res);
          chk({addr_flag_o, mem_req_o, bad_mode_o} == {e.addr, e.mem, e.bad},
              {e.tag, " flags"}, {29'd0, addr_flag_o, mem_req_o, bad_mode_o},
              {29'd0, e.addr, e.mem, e.bad});
          last = e;
        end
      end else begin
        chk(result_o == last.res && mem_req_o == last.mem && bad_mode_o == last.bad,
            "R10 hold", result_o, last.res);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    last.res = 0; last.addr = 0; last.mem = 0; last.bad = 0; last.tag = "R11";
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    #1;
    chk(valid_o == 0, "R11 valid", {31'd0, valid_o}, 32'd0);
    chk(result_o == 0 && !addr_flag_o && !mem_req_o && !bad_mode_o,
        "R11 outputs", result_o, 32'd0);
    mon_on = 1;

    send(3'd0, 16'h1234, 32'hDEAD_BEEF, 32'h1, 3);
    send(3'd1, 16'h8000, 32'h5, 32'h6, 2);          // R2 negative absolute
    send(3'd1, 16'h7FFF, 32'h5, 32'h6, 1);
    send(3'd2, 16'hFFFE, 32'h9, 32'h9, 2);          // R3 -2
    send(3'd3, 16'h0000, 32'h0000_1000, 32'h7, 1);
    send(3'd4, 16'h0010, 32'h0000_2000, 32'h0, 1);
    send(3'd4, 16'hFFFC, 32'h0000_0002, 32'h0, 2);  // R5 wraps below zero
    send(3'd5, 16'h5555, 32'hFFFF_FFF0, 32'h20, 1); // R6 wraps
    send(3'd6, 16'h000C, 32'h0000_0100, 32'h40, 1);
    send(3'd6, 16'hFFFF, 32'h8000_0000, 32'h8000_0001, 2); // R7 wrap
    send(3'd7, 16'h1111, 32'hAAAA_AAAA, 32'h5555_5555, 3);
    for (int k = 0; k < 8; k++) send_b2b(3'(k), 16'(k * 16'h1357), 32'h1000_0000 * k, 32'h0F0F_0F0F + k);
    @(negedge clk); req_i = 0;
    for (int k = 0; k < 40; k++) send(3'($urandom), 16'($urandom), $urandom, $urandom, 1 + k % 3);
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R9 all results seen", q.size(), 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule